// File: doc/BRIEF.md
# Mode-banked register file with cross-mode transfer port

This block holds the general registers and saved status registers of a processor core that runs in several operating modes. Some registers exist once for all modes, others have a private copy per mode. Ordinary reads and writes, indexed 0 to 15, always reach the copy that the current mode sees. A second port, the transfer port, lets privileged code name a copy that belongs to a different mode and read or write it directly, without switching modes.

The transfer port takes a 5-bit selector made of a 1-bit high field (most significant) and a 4-bit low field. It also takes a flag that picks between general registers and saved status registers. The block flags the request as illegal when the selector names nothing, when the current mode is unprivileged, or when the named copy is the one the current mode already reaches with an ordinary access. An illegal request changes no register and returns zero.

Top module: `banked_regfile`

## Requirements
- R1: Ordinary writes through `wr_idx` take effect on the next rising clock edge. Reads through each `rd_idx` port are combinational. Registers 0 to 7 are one set shared by every mode. Index 15 is not stored: it reads zero and writes to it are dropped.
- R2: Mode codes are user 10000, FIQ 10001, IRQ 10010, supervisor 10011, monitor 10110, abort 10111, hypervisor 11010, undefined 11011 and system 11111. FIQ has private registers 8 to 14. IRQ, supervisor, abort, undefined and monitor each have a private 13 and 14. Hypervisor has a private 13 and uses the user 14. User mode, system mode and any unlisted code use the user copies.
- R3: `spsr_rdata` returns the saved status register of the current mode, and `spsr_wr_en` writes it on the next edge. User mode and system mode have none: they read zero and their writes change nothing.
- R4: A general transfer whose selector bits [4:3] are 00 reaches user register 8+n, and one with bits [4:3] = 01 reaches FIQ register 8+n, where n is bits [2:0] and runs from 0 to 6.
- R5: A general transfer whose selector bits [4:3] are 10 reaches IRQ (bits [2:1]=00), supervisor (01), abort (10) or undefined (11). Bit 0 = 0 picks that mode's 14 and bit 0 = 1 picks its 13.
- R6: A general transfer whose selector bits [4:3] are 11 and whose bit 2 is 0 works as follows. With bit 1 = 0 it reaches monitor 14 (bit 0 = 0) or monitor 13 (bit 0 = 1). With bit 1 = 1 it reaches hypervisor 13 (bit 0 = 1) or the hypervisor exception return address (bit 0 = 0).
- R7: A status transfer reaches a saved status register through selector 01110 (FIQ), 10000 (IRQ), 10010 (supervisor), 10100 (abort), 10110 (undefined), 11100 (monitor) or 11110 (hypervisor).
- R8: Any transfer made in user mode, or in an unlisted mode, raises `xfer_illegal`, reads zero and changes no register.
- R9: A transfer raises `xfer_illegal` and changes nothing when its target is the same copy that the current mode reaches with an ordinary access at that index. The same applies to the current mode's own saved status register, and to the exception return address when the current mode is hypervisor.
- R10: A transfer whose selector names nothing raises `xfer_illegal`, reads zero and changes nothing. This covers general n = 7 in groups 00 and 01, general 111xx, and any status code outside the R7 list.
- R11: A legal transfer write takes effect on the next rising edge. A legal transfer read returns the selected copy combinationally.
- R12: While `rst_n` is low, every stored register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cur_mode | input | 5 | Current operating mode code |
| rd_idx | input | N_RD*4 | Register index for each ordinary read port |
| rd_data | output | N_RD*DW | Data for each ordinary read port |
| wr_en | input | 1 | Ordinary write enable |
| wr_idx | input | 4 | Ordinary write index |
| wr_data | input | DW | Ordinary write data |
| spsr_rdata | output | DW | Saved status of the current mode |
| spsr_wr_en | input | 1 | Write enable for the current mode's saved status |
| spsr_wdata | input | DW | Saved status write data |
| xfer_en | input | 1 | Transfer request valid |
| xfer_write | input | 1 | Transfer is a write (else a read) |
| xfer_status | input | 1 | Transfer targets a saved status register |
| xfer_hi | input | 1 | Selector bit 4 |
| xfer_lo | input | 4 | Selector bits 3 to 0 |
| xfer_wdata | input | DW | Transfer write data |
| xfer_rdata | output | DW | Transfer read data, zero when illegal |
| xfer_illegal | output | 1 | Transfer request refused |

## Verification
The bench fills every bank with values that encode their owner. It then checks that each selector group lands on the right copy. A decoder that swapped the 13/14 meaning of bit 0, or the order of the four middle modes, would return another mode's value. The own-copy rule is probed where it is easy to get wrong: user registers 8 to 12 from IRQ mode (physically shared), user 13 from system mode, hypervisor 14 (aliased onto the user copy) and the return address from hypervisor mode. A design that checked only the mode and not the physical copy would accept those requests. Illegal writes are followed by ordinary reads of the copy they aimed at, so a design that gated only the flag, and not the write, would show corrupted data.

// File: rtl/banked_rf_pkg.sv
package banked_rf_pkg;

   localparam int NSLOT  = 41;
   localparam int SLOT_W = 6;

   localparam logic [4:0] MD_USR = 5'b10000;
   localparam logic [4:0] MD_FIQ = 5'b10001;
   localparam logic [4:0] MD_IRQ = 5'b10010;
   localparam logic [4:0] MD_SVC = 5'b10011;
   localparam logic [4:0] MD_MON = 5'b10110;
   localparam logic [4:0] MD_ABT = 5'b10111;
   localparam logic [4:0] MD_HYP = 5'b11010;
   localparam logic [4:0] MD_UND = 5'b11011;
   localparam logic [4:0] MD_SYS = 5'b11111;

   // physical slot layout
   localparam logic [SLOT_W-1:0] SL_FIQ_R8 = 6'd15;
   localparam logic [SLOT_W-1:0] SL_ELR    = 6'd33;
   localparam logic [SLOT_W-1:0] SL_SPSR_M = 6'd33;  // + bank number (FIQ=1)

   typedef enum logic [2:0] {
      BK_USR = 3'd0, BK_FIQ = 3'd1, BK_IRQ = 3'd2, BK_SVC = 3'd3,
      BK_ABT = 3'd4, BK_UND = 3'd5, BK_MON = 3'd6, BK_HYP = 3'd7
   } bank_e;

   typedef struct packed {
      logic              ok;
      logic [SLOT_W-1:0] idx;
   } slot_t;

   function automatic bank_e mode_bank(input logic [4:0] m);
      case (m)
         MD_FIQ:  return BK_FIQ;
         MD_IRQ:  return BK_IRQ;
         MD_SVC:  return BK_SVC;
         MD_ABT:  return BK_ABT;
         MD_UND:  return BK_UND;
         MD_MON:  return BK_MON;
         MD_HYP:  return BK_HYP;
         default: return BK_USR;
      endcase
   endfunction

   function automatic logic mode_priv(input logic [4:0] m);
      case (m)
         MD_FIQ, MD_IRQ, MD_SVC, MD_ABT,
         MD_UND, MD_MON, MD_HYP, MD_SYS: return 1'b1;
         default:                        return 1'b0;
      endcase
   endfunction

   function automatic logic [SLOT_W-1:0] sp_slot(input bank_e b);
      case (b)
         BK_FIQ:  return 6'd20;
         BK_IRQ:  return 6'd22;
         BK_SVC:  return 6'd24;
         BK_ABT:  return 6'd26;
         BK_UND:  return 6'd28;
         BK_MON:  return 6'd30;
         BK_HYP:  return 6'd32;
         default: return 6'd13;
      endcase
   endfunction

   function automatic logic [SLOT_W-1:0] lr_slot(input bank_e b);
      case (b)
         BK_FIQ:  return 6'd21;
         BK_IRQ:  return 6'd23;
         BK_SVC:  return 6'd25;
         BK_ABT:  return 6'd27;
         BK_UND:  return 6'd29;
         BK_MON:  return 6'd31;
         default: return 6'd14;   // user, and hypervisor shares it
      endcase
   endfunction

   function automatic slot_t normal_slot(input bank_e b, input logic [3:0] r);
      slot_t s;
      s.ok  = 1'b1;
      s.idx = {2'b00, r};
      if (r == 4'd15) begin
         s.ok  = 1'b0;
         s.idx = '0;
      end else if (r[3] && b == BK_FIQ) begin
         s.idx = SL_FIQ_R8 + {3'b000, r[2:0]};
      end else if (r == 4'd13) begin
         s.idx = sp_slot(b);
      end else if (r == 4'd14) begin
         s.idx = lr_slot(b);
      end
      return s;
   endfunction

   function automatic slot_t spsr_slot(input bank_e b);
      slot_t s;
      s.ok  = (b != BK_USR);
      s.idx = SL_SPSR_M + {3'b000, b};
      return s;
   endfunction

endpackage

// File: rtl/banked_slot_map.sv
module banked_slot_map
   import banked_rf_pkg::*;
(
   input  bank_e             bank,
   input  logic [3:0]        idx,
   output logic              ok,
   output logic [SLOT_W-1:0] slot
);

   slot_t s;

   always_comb begin
      s    = normal_slot(bank, idx);
      ok   = s.ok;
      slot = s.idx;
   end

endmodule

// File: rtl/banked_xfer_decode.sv
module banked_xfer_decode
   import banked_rf_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [4:0]        mode,
   input  logic [4:0]        sel,
   input  logic              status,
   output logic              legal,
   output logic [SLOT_W-1:0] slot
);

   bank_e             cur_b;
   bank_e             tgt_b;
   logic              priv;
   logic              tgt_ok;
   logic              own;
   logic              use_arch;
   logic [3:0]        arch;
   logic [SLOT_W-1:0] tgt;
   slot_t             ns;
   slot_t             ss;
   localparam bank_e MID_BANKS [4] = '{BK_IRQ, BK_SVC, BK_ABT, BK_UND};

   always_comb begin
      cur_b    = mode_bank(mode);
      priv     = mode_priv(mode);
      tgt_b    = BK_USR;
      tgt_ok   = 1'b0;
      tgt      = '0;
      own      = 1'b0;
      use_arch = 1'b0;
      arch     = 4'd0;
      ns       = '0;
      ss       = '0;
      if (status) begin
         tgt_ok = 1'b1;
         case (sel)
            5'b01110: tgt_b = BK_FIQ;
            5'b10000: tgt_b = BK_IRQ;
            5'b10010: tgt_b = BK_SVC;
            5'b10100: tgt_b = BK_ABT;
            5'b10110: tgt_b = BK_UND;
            5'b11100: tgt_b = BK_MON;
            5'b11110: tgt_b = BK_HYP;
            default:  tgt_ok = 1'b0;
         endcase
         ss  = spsr_slot(tgt_b);
         tgt = ss.idx;
         own = (tgt_b == cur_b);
      end else begin
         case (sel[4:3])
            2'b00, 2'b01: begin
               tgt_ok   = (sel[2:0] != 3'b111);
               tgt      = (sel[3] ? SL_FIQ_R8 : 6'd8) + {3'b000, sel[2:0]};
               arch     = {1'b1, sel[2:0]};
               use_arch = 1'b1;
            end
            2'b10: begin
               tgt_b    = MID_BANKS[sel[2:1]];
               tgt_ok   = 1'b1;
               tgt      = sel[0] ? sp_slot(tgt_b) : lr_slot(tgt_b);
               arch     = sel[0] ? 4'd13 : 4'd14;
               use_arch = 1'b1;
            end
            default: begin
               if (!sel[2]) begin
                  tgt_ok = 1'b1;
                  if (!sel[1]) begin
                     tgt_b    = BK_MON;
                     tgt      = sel[0] ? sp_slot(BK_MON) : lr_slot(BK_MON);
                     arch     = sel[0] ? 4'd13 : 4'd14;
                     use_arch = 1'b1;
                  end else if (sel[0]) begin
                     tgt_b    = BK_HYP;
                     tgt      = sp_slot(BK_HYP);
                     arch     = 4'd13;
                     use_arch = 1'b1;
                  end else begin
                     tgt_b = BK_HYP;
                     tgt   = SL_ELR;
                     own   = (cur_b == BK_HYP);
                  end
               end
            end
         endcase
         if (use_arch) begin
            ns  = normal_slot(cur_b, arch);
            own = ns.ok && (ns.idx == tgt);
         end
      end
      legal = en && priv && tgt_ok && !own;
      slot  = tgt;
   end

   assert_status_slot_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (en && status && legal) |-> (slot >= 6'd34 && slot <= 6'd40));

   assert_user_denied_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (en && mode == MD_USR) |-> !legal);

   assert_hyp_return_own_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !status && sel == 5'b11010 && mode == MD_HYP) |-> !legal);

endmodule

// File: rtl/banked_store.sv
module banked_store #(
   parameter int NSLOT = 41,
   parameter int SW    = 6,
   parameter int DW    = 32,
   parameter int NRP   = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             n_we,
   input  logic [SW-1:0]    n_slot,
   input  logic [DW-1:0]    n_data,
   input  logic             s_we,
   input  logic [SW-1:0]    s_slot,
   input  logic [DW-1:0]    s_data,
   input  logic             x_we,
   input  logic [SW-1:0]    x_slot,
   input  logic [DW-1:0]    x_data,
   input  logic [NRP*SW-1:0] raddr,
   output logic [NRP*DW-1:0] rdata
);

   if (NSLOT > (1 << SW)) begin : g_bad_sw
      $error("banked_store: SW too narrow for NSLOT");
   end

   logic [DW-1:0] q [NSLOT];

   // transfer port has priority, then status port, then ordinary port
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < NSLOT; s++) q[s] <= '0;
      end else begin
         for (int s = 0; s < NSLOT; s++) begin
            if (x_we && x_slot == SW'(s))      q[s] <= x_data;
            else if (s_we && s_slot == SW'(s)) q[s] <= s_data;
            else if (n_we && n_slot == SW'(s)) q[s] <= n_data;
         end
      end
   end

   for (genvar p = 0; p < NRP; p++) begin : g_rd
      logic [SW-1:0] a;
      assign a = raddr[p*SW +: SW];
      assign rdata[p*DW +: DW] = (int'(a) < NSLOT) ? q[a] : '0;
   end

   assert_xfer_write_lands_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (x_we && int'(x_slot) < NSLOT) |=> (q[$past(x_slot)] == $past(x_data)));

   assert_normal_write_lands_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (n_we && !(x_we && x_slot == n_slot) && int'(n_slot) < NSLOT)
      |=> (q[$past(n_slot)] == $past(n_data)));

endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
   import banked_rf_pkg::*;
#(
   parameter int DW   = 32,
   parameter int N_RD = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [4:0]        cur_mode,
   input  logic [N_RD*4-1:0] rd_idx,
   output logic [N_RD*DW-1:0] rd_data,
   input  logic              wr_en,
   input  logic [3:0]        wr_idx,
   input  logic [DW-1:0]     wr_data,
   output logic [DW-1:0]     spsr_rdata,
   input  logic              spsr_wr_en,
   input  logic [DW-1:0]     spsr_wdata,
   input  logic              xfer_en,
   input  logic              xfer_write,
   input  logic              xfer_status,
   input  logic              xfer_hi,
   input  logic [3:0]        xfer_lo,
   input  logic [DW-1:0]     xfer_wdata,
   output logic [DW-1:0]     xfer_rdata,
   output logic              xfer_illegal
);

   localparam int NRP    = N_RD + 2;
   localparam int P_SPSR = N_RD;
   localparam int P_XFER = N_RD + 1;

   if (DW < 1) begin : g_bad_dw
      $error("banked_regfile: DW must be positive");
   end
   if (N_RD < 1 || N_RD > 8) begin : g_bad_nrd
      $error("banked_regfile: N_RD out of range 1..8");
   end

   bank_e              cur_b;
   slot_t              sp_s;
   logic [NRP*SW_T-1:0] raddr;
   logic [NRP*DW-1:0]  rdata;
   logic [N_RD-1:0]    r_ok;
   logic               w_ok;
   logic [SLOT_W-1:0]  w_slot;
   logic               x_legal;
   logic [SLOT_W-1:0]  x_slot;

   localparam int SW_T = SLOT_W;

   assign cur_b = mode_bank(cur_mode);
   assign sp_s  = spsr_slot(cur_b);

   for (genvar i = 0; i < N_RD; i++) begin : g_rport
      logic [SLOT_W-1:0] rs;
      banked_slot_map u_map (
         .bank (cur_b),
         .idx  (rd_idx[i*4 +: 4]),
         .ok   (r_ok[i]),
         .slot (rs)
      );
      assign raddr[i*SLOT_W +: SLOT_W] = rs;
      assign rd_data[i*DW +: DW] = r_ok[i] ? rdata[i*DW +: DW] : '0;
   end

   banked_slot_map u_wmap (
      .bank (cur_b),
      .idx  (wr_idx),
      .ok   (w_ok),
      .slot (w_slot)
   );

   banked_xfer_decode u_dec (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (xfer_en),
      .mode   (cur_mode),
      .sel    ({xfer_hi, xfer_lo}),
      .status (xfer_status),
      .legal  (x_legal),
      .slot   (x_slot)
   );

   assign raddr[P_SPSR*SLOT_W +: SLOT_W] = sp_s.idx;
   assign raddr[P_XFER*SLOT_W +: SLOT_W] = x_slot;

   banked_store #(
      .NSLOT (NSLOT),
      .SW    (SLOT_W),
      .DW    (DW),
      .NRP   (NRP)
   ) u_store (
      .clk    (clk),
      .rst_n  (rst_n),
      .n_we   (wr_en && w_ok),
      .n_slot (w_slot),
      .n_data (wr_data),
      .s_we   (spsr_wr_en && sp_s.ok),
      .s_slot (sp_s.idx),
      .s_data (spsr_wdata),
      .x_we   (x_legal && xfer_write),
      .x_slot (x_slot),
      .x_data (xfer_wdata),
      .raddr  (raddr),
      .rdata  (rdata)
   );

   assign spsr_rdata   = sp_s.ok ? rdata[P_SPSR*DW +: DW] : '0;
   assign xfer_rdata   = x_legal ? rdata[P_XFER*DW +: DW] : '0;
   assign xfer_illegal = xfer_en && !x_legal;

   assert_illegal_reads_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_illegal |-> (xfer_rdata == '0));

   assert_user_no_status_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_mode == MD_USR || cur_mode == MD_SYS) |-> (spsr_rdata == '0));

endmodule

// File: tb/test_banked_regfile.sv
`timescale 1ns/1ps
module test_banked_regfile;

   localparam logic [4:0] USR = 5'b10000, FIQ = 5'b10001, IRQ = 5'b10010,
                          SVC = 5'b10011, MON = 5'b10110, ABT = 5'b10111,
                          HYP = 5'b11010, UND = 5'b11011, SYS = 5'b11111;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  cur_mode = SVC;
   logic [7:0]  rd_idx = '0;
   logic [63:0] rd_data;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_idx = '0;
   logic [31:0] wr_data = '0;
   logic [31:0] spsr_rdata;
   logic        spsr_wr_en = 1'b0;
   logic [31:0] spsr_wdata = '0;
   logic        xfer_en = 1'b0;
   logic        xfer_write = 1'b0;
   logic        xfer_status = 1'b0;
   logic        xfer_hi = 1'b0;
   logic [3:0]  xfer_lo = '0;
   logic [31:0] xfer_wdata = '0;
   logic [31:0] xfer_rdata;
   logic        xfer_illegal;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   banked_regfile #(.DW(32), .N_RD(2)) i_banked_regfile (
      .clk, .rst_n, .cur_mode, .rd_idx, .rd_data, .wr_en, .wr_idx, .wr_data,
      .spsr_rdata, .spsr_wr_en, .spsr_wdata, .xfer_en, .xfer_write,
      .xfer_status, .xfer_hi, .xfer_lo, .xfer_wdata, .xfer_rdata, .xfer_illegal
   );

   function automatic logic [31:0] sp_v(input logic [4:0] m);
      return 32'h0D00_0000 | (32'(m) << 8);
   endfunction
   function automatic logic [31:0] lr_v(input logic [4:0] m);
      return 32'h0E00_0000 | (32'(m) << 8);
   endfunction
   function automatic logic [31:0] sr_v(input logic [4:0] m);
      return 32'h5000_0000 | 32'(m);
   endfunction

   task automatic chk(input string req, input string what,
                      input logic [31:0] got, input logic [31:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
      end
   endtask

   task automatic set_mode(input logic [4:0] m);
      @(negedge clk);
      cur_mode = m;
   endtask

   task automatic nwrite(input logic [3:0] idx, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_idx = idx; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic nread(input logic [3:0] idx, output logic [31:0] d);
      @(negedge clk);
      rd_idx[3:0] = idx;
      #1 d = rd_data[31:0];
   endtask

   task automatic swrite(input logic [31:0] d);
      @(negedge clk);
      spsr_wr_en = 1'b1; spsr_wdata = d;
      @(negedge clk);
      spsr_wr_en = 1'b0;
   endtask

   task automatic xread(input logic [4:0] sel, input logic st,
                        output logic [31:0] d, output logic ill);
      @(negedge clk);
      xfer_en = 1'b1; xfer_write = 1'b0; xfer_status = st;
      {xfer_hi, xfer_lo} = sel;
      #1 d = xfer_rdata; ill = xfer_illegal;
      xfer_en = 1'b0;
   endtask

   task automatic xwrite(input logic [4:0] sel, input logic st,
                         input logic [31:0] dat, output logic ill);
      @(negedge clk);
      xfer_en = 1'b1; xfer_write = 1'b1; xfer_status = st;
      {xfer_hi, xfer_lo} = sel; xfer_wdata = dat;
      #1 ill = xfer_illegal;
      @(negedge clk);
      xfer_en = 1'b0; xfer_write = 1'b0;
   endtask

   // check a legal transfer read
   task automatic xexp(input string req, input logic [4:0] sel, input logic st,
                       input logic [31:0] exp);
      logic [31:0] d; logic ill;
      xread(sel, st, d, ill);
      chk(req, $sformatf("xfer sel %b st %0d data", sel, st), d, exp);
      chk(req, $sformatf("xfer sel %b st %0d flag", sel, st), 32'(ill), 32'd0);
   endtask

   // check a refused transfer read
   task automatic xdeny(input string req, input logic [4:0] sel, input logic st);
      logic [31:0] d; logic ill;
      xread(sel, st, d, ill);
      chk(req, $sformatf("deny sel %b st %0d flag", sel, st), 32'(ill), 32'd1);
      chk(req, $sformatf("deny sel %b st %0d data", sel, st), d, 32'd0);
   endtask

   task automatic t_reset;
      logic [31:0] d;
      set_mode(SVC);
      nread(4'd0, d);  chk("R12", "reset R0", d, 32'd0);
      nread(4'd13, d); chk("R12", "reset R13", d, 32'd0);
      #0 chk("R12", "reset status", spsr_rdata, 32'd0);
      xexp("R12", 5'b11010, 1'b0, 32'd0);
   endtask

   task automatic t_normal;
      logic [31:0] d;
      logic [4:0] mids [5] = '{IRQ, SVC, ABT, UND, MON};
      set_mode(USR);
      nwrite(4'd0, 32'h1111_0000);
      nwrite(4'd7, 32'h7777_0000);
      for (int i = 8; i <= 14; i++) nwrite(4'(i), 32'hA000_0000 + 32'(i));
      nwrite(4'd15, 32'hDEAD_0015);
      set_mode(FIQ);
      for (int i = 8; i <= 14; i++) nwrite(4'(i), 32'hF000_0000 + 32'(i));
      foreach (mids[k]) begin
         set_mode(mids[k]);
         nwrite(4'd13, sp_v(mids[k]));
         nwrite(4'd14, lr_v(mids[k]));
      end
      set_mode(HYP);
      nwrite(4'd13, sp_v(HYP));
      set_mode(FIQ);
      nread(4'd0, d);  chk("R1", "shared R0 seen in FIQ", d, 32'h1111_0000);
      nread(4'd7, d);  chk("R1", "shared R7 seen in FIQ", d, 32'h7777_0000);
      nread(4'd15, d); chk("R1", "index 15 reads zero", d, 32'd0);
      nread(4'd8, d);  chk("R2", "FIQ private R8", d, 32'hF000_0008);
      rd_idx[7:4] = 4'd14;
      #1 chk("R1", "second read port FIQ R14", rd_data[63:32], 32'hF000_000E);
      set_mode(USR);
      nread(4'd8, d);  chk("R2", "user R8", d, 32'hA000_0008);
      nread(4'd13, d); chk("R2", "user R13", d, 32'hA000_000D);
      foreach (mids[k]) begin
         set_mode(mids[k]);
         nread(4'd13, d); chk("R2", $sformatf("mode %b R13", mids[k]), d, sp_v(mids[k]));
         nread(4'd14, d); chk("R2", $sformatf("mode %b R14", mids[k]), d, lr_v(mids[k]));
         nread(4'd12, d); chk("R2", $sformatf("mode %b R12 shared", mids[k]), d, 32'hA000_000C);
      end
      set_mode(HYP);
      nread(4'd13, d); chk("R2", "hyp R13", d, sp_v(HYP));
      nread(4'd14, d); chk("R2", "hyp R14 is user copy", d, 32'hA000_000E);
      set_mode(SYS);
      nread(4'd13, d); chk("R2", "system uses user R13", d, 32'hA000_000D);
      set_mode(5'b00000);
      nread(4'd9, d);  chk("R2", "unlisted mode uses user R9", d, 32'hA000_0009);
   endtask

   task automatic t_status;
      logic [4:0] ms [7] = '{FIQ, IRQ, SVC, ABT, UND, MON, HYP};
      foreach (ms[k]) begin
         set_mode(ms[k]);
         swrite(sr_v(ms[k]));
      end
      foreach (ms[k]) begin
         set_mode(ms[k]);
         #1 chk("R3", $sformatf("status of mode %b", ms[k]), spsr_rdata, sr_v(ms[k]));
      end
      set_mode(USR);
      swrite(32'hBAD0_0001);
      #1 chk("R3", "user status reads zero", spsr_rdata, 32'd0);
      set_mode(SYS);
      swrite(32'hBAD0_0002);
      #1 chk("R3", "system status reads zero", spsr_rdata, 32'd0);
      set_mode(FIQ);
      #1 chk("R3", "FIQ status untouched by user/system writes", spsr_rdata, sr_v(FIQ));
   endtask

   task automatic t_xfer_read;
      logic [4:0] mids [4] = '{IRQ, SVC, ABT, UND};
      set_mode(FIQ);
      for (int n = 0; n < 7; n++)
         xexp("R4", {2'b00, 3'(n)}, 1'b0, 32'hA000_0008 + 32'(n));
      xdeny("R10", 5'b00111, 1'b0);
      set_mode(MON);
      for (int n = 0; n < 7; n++)
         xexp("R4", {2'b01, 3'(n)}, 1'b0, 32'hF000_0008 + 32'(n));
      xdeny("R10", 5'b01111, 1'b0);
      foreach (mids[k]) begin
         xexp("R5", {2'b10, 2'(k), 1'b0}, 1'b0, lr_v(mids[k]));
         xexp("R5", {2'b10, 2'(k), 1'b1}, 1'b0, sp_v(mids[k]));
      end
      set_mode(SVC);
      xexp("R6", 5'b11000, 1'b0, lr_v(MON));
      xexp("R6", 5'b11001, 1'b0, sp_v(MON));
      xexp("R6", 5'b11011, 1'b0, sp_v(HYP));
      xexp("R6", 5'b11010, 1'b0, 32'd0);
      xdeny("R10", 5'b11100, 1'b0);
      xdeny("R10", 5'b11111, 1'b0);
      xexp("R7", 5'b01110, 1'b1, sr_v(FIQ));
      xexp("R7", 5'b10000, 1'b1, sr_v(IRQ));
      xexp("R7", 5'b10100, 1'b1, sr_v(ABT));
      xexp("R7", 5'b10110, 1'b1, sr_v(UND));
      xexp("R7", 5'b11100, 1'b1, sr_v(MON));
      xexp("R7", 5'b11110, 1'b1, sr_v(HYP));
      xdeny("R9", 5'b10010, 1'b1);
      xdeny("R10", 5'b00000, 1'b1);
      xdeny("R10", 5'b01111, 1'b1);
   endtask

   task automatic t_xfer_write;
      logic ill;
      logic [31:0] d;
      set_mode(SVC);
      xwrite(5'b11010, 1'b0, 32'h1234_5678, ill);
      chk("R11", "return-address write flag", 32'(ill), 32'd0);
      xexp("R11", 5'b11010, 1'b0, 32'h1234_5678);
      xwrite(5'b10101, 1'b0, 32'hABAB_0001, ill);
      set_mode(ABT);
      nread(4'd13, d); chk("R11", "abort R13 written by transfer", d, 32'hABAB_0001);
      set_mode(MON);
      xwrite(5'b01110, 1'b1, 32'h6000_00FF, ill);
      set_mode(FIQ);
      #1 chk("R11", "FIQ status written by transfer", spsr_rdata, 32'h6000_00FF);
   endtask

   task automatic t_deny;
      logic ill;
      logic [31:0] d;
      set_mode(USR);
      xdeny("R8", 5'b11001, 1'b0);
      xwrite(5'b11001, 1'b0, 32'hDEAD_BEEF, ill);
      chk("R8", "user write flag", 32'(ill), 32'd1);
      set_mode(5'b00000);
      xdeny("R8", 5'b11001, 1'b0);
      set_mode(SVC);
      xexp("R8", 5'b11001, 1'b0, sp_v(MON));
      set_mode(FIQ);
      xdeny("R9", 5'b01000, 1'b0);
      xwrite(5'b01000, 1'b0, 32'hDEAD_0008, ill);
      chk("R9", "own FIQ R8 write flag", 32'(ill), 32'd1);
      nread(4'd8, d); chk("R9", "FIQ R8 unchanged", d, 32'hF000_0008);
      set_mode(SYS);
      xdeny("R9", 5'b00101, 1'b0);
      set_mode(IRQ);
      xdeny("R9", 5'b00000, 1'b0);
      set_mode(HYP);
      xdeny("R9", 5'b11011, 1'b0);
      xdeny("R9", 5'b11010, 1'b0);
      xdeny("R9", 5'b00110, 1'b0);
      set_mode(MON);
      xwrite(5'b11001, 1'b0, 32'hDEAD_0013, ill);
      chk("R9", "own monitor R13 write flag", 32'(ill), 32'd1);
      nread(4'd13, d); chk("R9", "monitor R13 unchanged", d, sp_v(MON));
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_normal();
      t_status();
      t_xfer_read();
      t_xfer_write();
      t_deny();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule